// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus. Software programs a reload value, sets a run bit, and must then prove that it is alive by writing an ordered pair of key words to a service register before a 32-bit down-counter reaches zero. A correct pair reloads the counter from the programmed value. If the counter runs out, the block raises a sticky expiry output. The reset controller or system logic consumes that output. Only a reset clears it.

The control register holds the run bit, two gating bits and a two-bit service-mode field. The first gating bit holds the count while an external debug-halt input is high. The second holds the count while a low-power input is high. The service-mode field is stored and read back, and only the fixed-pair mode is implemented. A reload value below a minimum is raised to that minimum when it enters the counter. Software sees the live count only after it has cleared the run bit. While the watchdog runs, the count readback returns zero.

Top module: `wdt_seq_guard`

## Requirements
- R1: The byte offsets are: control at 0x00, reload at 0x08, service at 0x10, count readback at 0x14. A read returns its data one clock after the read strobe. Control reads back bit 0 (run), bit 1 (halt gate), bit 2 (low-power gate) and bits 10:9 (service mode), with every other bit 0. Reload reads back the last value written. Service reads as 0. The reset values are control 0, reload 0x400 and count 0.
- R2: A control write that changes the run bit from 0 to 1 loads the counter from the reload register on the same clock edge.
- R3: While running and not gated, the counter drops by exactly one per clock until it reaches 0.
- R4: While running, a service write of 0x0000A602 followed directly by a service write of 0x0000B480 reloads the counter on the edge of the second write.
- R5: A 0xB480 service write that does not directly follow a 0xA602 service write leaves the counter alone. Any other service value also resets the pair checker to idle.
- R6: A write to the reload register does not change a running count. The new value is used at the next reload, whether from service or from enable.
- R7: A reload value below 0x100 is loaded into the counter as 0x100.
- R8: With the halt gate set, the count holds while the debug-halt input is high. With the low-power gate set, the count holds while the low-power input is high. With the low-power gate clear, the count keeps running while the low-power input is high.
- R9: The count readback returns 0 while the run bit is 1. It returns the held count while the run bit is 0. A stopped counter does not change.
- R10: The expiry output goes high on the edge where the counter steps from 1 to 0. It then stays high through disable, reload and service until reset.
- R11: Service writes while the run bit is 0 leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| halt_i | input | 1 | Debug-halt request |
| lowpwr_i | input | 1 | Low-power request |
| expired_o | output | 1 | Sticky expiry flag |

## Verification
On every cycle, the assertions check that expiry is sticky and that every load lands at or above the minimum. They also check that the count steps by one when ungated, holds when stopped or halt-gated, and reads back as zero while running, and that a completed key pair only occurs while running. The bench scenarios are the only way to show the sequence rules: a lone second key, an intruding word and a repeated first key. The scenarios also cover the deferred effect of reload writes, the low-power gate in both settings and the exact clamp value. These need histories longer than one clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_DATA_W = 32;
  localparam int WDT_ADDR_W = 5;

  localparam logic [WDT_ADDR_W-1:0] OFS_CTL    = 5'h00;
  localparam logic [WDT_ADDR_W-1:0] OFS_RELOAD = 5'h08;
  localparam logic [WDT_ADDR_W-1:0] OFS_SVC    = 5'h10;
  localparam logic [WDT_ADDR_W-1:0] OFS_COUNT  = 5'h14;

  localparam int BIT_RUN   = 0;
  localparam int BIT_HALT  = 1;
  localparam int BIT_LOWP  = 2;
  localparam int BIT_MODE0 = 9;
  localparam int BIT_MODE1 = 10;

  typedef struct packed {
    logic [1:0] mode;
    logic       lowp_gate;
    logic       halt_gate;
    logic       run;
  } wdt_ctl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W-1:0] RELOAD_RST = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  output wdt_ctl_t          ctl,
  output logic [DATA_W-1:0] reload,
  output logic              run_rise,
  output logic              svc_wr,
  output logic [DATA_W-1:0] rdata
);
  logic sel_ctl, sel_rel, sel_svc, sel_cnt;
  logic [DATA_W-1:0] ctl_view;
  logic [DATA_W-1:0] rd_mux;

  assign sel_ctl = (addr == OFS_CTL);
  assign sel_rel = (addr == OFS_RELOAD);
  assign sel_svc = (addr == OFS_SVC);
  assign sel_cnt = (addr == OFS_COUNT);

  assign run_rise = wr && sel_ctl && wdata[BIT_RUN] && !ctl.run;
  assign svc_wr   = wr && sel_svc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      reload <= RELOAD_RST;
    end else if (wr) begin
      if (sel_ctl) begin
        ctl.run       <= wdata[BIT_RUN];
        ctl.halt_gate <= wdata[BIT_HALT];
        ctl.lowp_gate <= wdata[BIT_LOWP];
        ctl.mode      <= {wdata[BIT_MODE1], wdata[BIT_MODE0]};
      end
      if (sel_rel) reload <= wdata;
    end
  end

  always_comb begin
    ctl_view            = '0;
    ctl_view[BIT_RUN]   = ctl.run;
    ctl_view[BIT_HALT]  = ctl.halt_gate;
    ctl_view[BIT_LOWP]  = ctl.lowp_gate;
    ctl_view[BIT_MODE0] = ctl.mode[0];
    ctl_view[BIT_MODE1] = ctl.mode[1];
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctl)      rd_mux = ctl_view;
    else if (sel_rel) rd_mux = reload;
    else if (sel_cnt) rd_mux = ctl.run ? '0 : count;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_A602,
  parameter logic [DATA_W-1:0] KEY_SECOND = 32'h0000_B480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              svc_ok
);
  typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_t;
  seq_t state;

  assign svc_ok = run && svc_wr && (state == SEQ_ARMED) && (wdata == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst || !run)  state <= SEQ_IDLE;
    else if (svc_wr)  state <= (wdata == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] MIN_LOAD = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              halt_gate,
  input  logic              lowp_gate,
  input  logic              halt_i,
  input  logic              lowpwr_i,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] count,
  output logic              ticking,
  output logic              expired
);
  logic [DATA_W-1:0] load_eff;

  generate
    if (MIN_LOAD == '0) begin : g_noclamp
      assign load_eff = load_val;
    end else begin : g_clamp
      assign load_eff = (load_val < MIN_LOAD) ? MIN_LOAD : load_val;
    end
  endgenerate

  assign ticking = run && !(halt_gate && halt_i) && !(lowp_gate && lowpwr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (load) begin
      count <= load_eff;
    end else if (ticking && count != '0) begin
      count <= count - 1'b1;
      if (count == {{(DATA_W-1){1'b0}}, 1'b1}) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_seq_guard.sv
module wdt_seq_guard
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W-1:0] RELOAD_RST = 32'h0000_0400,
  parameter logic [DATA_W-1:0] MIN_LOAD   = 32'h0000_0100,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_A602,
  parameter logic [DATA_W-1:0] KEY_SECOND = 32'h0000_B480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              halt_i,
  input  logic              lowpwr_i,
  output logic              expired_o
);
  wdt_ctl_t          ctl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] count;
  logic              run_rise, svc_wr, svc_ok, load, ticking;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .ctl(ctl), .reload(reload),
    .run_rise(run_rise), .svc_wr(svc_wr), .rdata(bus_rdata)
  );

  wdt_svc_seq #(.DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_seq (
    .clk(clk), .rst(rst), .run(ctl.run), .svc_wr(svc_wr),
    .wdata(bus_wdata), .svc_ok(svc_ok)
  );

  assign load = run_rise || svc_ok;

  wdt_down_counter #(.DATA_W(DATA_W), .MIN_LOAD(MIN_LOAD)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl.run), .halt_gate(ctl.halt_gate),
    .lowp_gate(ctl.lowp_gate), .halt_i(halt_i), .lowpwr_i(lowpwr_i),
    .load(load), .load_val(reload), .count(count), .ticking(ticking),
    .expired(expired_o)
  );
endmodule

// File: rtl/wdt_seq_guard_chk.sv
module wdt_seq_guard_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W-1:0] MIN_LOAD = 32'h0000_0100
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              halt_i,
  input logic              run,
  input logic              halt_gate,
  input logic              load,
  input logic              svc_ok,
  input logic              ticking,
  input logic [DATA_W-1:0] count,
  input logic              expired_o
);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> expired_o);

  assert_load_floor_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (count >= MIN_LOAD));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (ticking && !load && count != '0) |=> (count == $past(count) - 1'b1));

  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (run && halt_gate && halt_i && !load) |=> $stable(count));

  assert_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 5'h14 && run) |=> (bus_rdata == '0));

  assert_svc_needs_run_R11: assert property (@(posedge clk) disable iff (rst)
    svc_ok |-> run);
endmodule

bind wdt_seq_guard wdt_seq_guard_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MIN_LOAD(MIN_LOAD)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .halt_i(halt_i), .run(ctl.run), .halt_gate(ctl.halt_gate), .load(load),
  .svc_ok(svc_ok), .ticking(ticking), .count(count), .expired_o(expired_o)
);

// File: tb/wdt_seq_guard_test.sv
module wdt_seq_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        halt_i = 1'b0, lowpwr_i = 1'b0;
  logic        expired_o;

  int    n_tests = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  wdt_seq_guard uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt_i(halt_i),
    .lowpwr_i(lowpwr_i), .expired_o(expired_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_ctl, m_rel, m_cnt, m_rdata;
  bit          m_armed, m_exp;

  always @(posedge clk) begin
    bit run, tick, ld, ok;
    logic [31:0] lv;
    if (rst) begin
      m_ctl = 0; m_rel = 32'h400; m_cnt = 0; m_rdata = 0; m_armed = 0; m_exp = 0;
    end else begin
      run  = m_ctl[0];
      tick = run && !(m_ctl[1] && halt_i) && !(m_ctl[2] && lowpwr_i);
      if (bus_rd) begin
        case (bus_addr)
          5'h00:   m_rdata = m_ctl;
          5'h08:   m_rdata = m_rel;
          5'h14:   m_rdata = run ? 32'h0 : m_cnt;
          default: m_rdata = 0;
        endcase
      end
      ok = bus_wr && bus_addr == 5'h10 && bus_wdata == 32'hB480 && m_armed && run;
      ld = (bus_wr && bus_addr == 5'h00 && bus_wdata[0] && !run) || ok;
      lv = (m_rel < 32'h100) ? 32'h100 : m_rel;
      if (ld) m_cnt = lv;
      else if (tick && m_cnt != 0) begin
        if (m_cnt == 1) m_exp = 1;
        m_cnt = m_cnt - 1;
      end
      if (!run) m_armed = 0;
      else if (bus_wr && bus_addr == 5'h10) m_armed = (bus_wdata == 32'hA602);
      if (bus_wr && bus_addr == 5'h00) m_ctl = bus_wdata & 32'h0000_0607;
      if (bus_wr && bus_addr == 5'h08) m_rel = bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_tests++;
      if (bus_rdata !== m_rdata || expired_o !== m_exp) begin
        n_fail++;
        $display("FAIL %s model compare: rdata=%h exp=%b expected rdata=%h exp=%b",
                 cur_req, bus_rdata, expired_o, m_rdata, m_exp);
      end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      finish_up();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    n_tests++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read %h: actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic flag_chk(input bit exp, input string req);
    n_tests++;
    if (expired_o !== exp) begin
      n_fail++;
      $display("FAIL %s expiry: actual=%b expected=%b", req, expired_o, exp);
    end
  endtask

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state and readback
    cur_req = "R1";
    flag_chk(0, "R10");
    rd_chk(5'h00, 32'h0, "R1");
    rd_chk(5'h08, 32'h400, "R1");
    rd_chk(5'h14, 32'h0, "R9");
    wr(5'h08, 32'h300);
    rd_chk(5'h08, 32'h300, "R1");
    wr(5'h00, 32'hFFFF_FFFE);
    rd_chk(5'h00, 32'h606, "R1");
    wr(5'h00, 32'h0);
    rd_chk(5'h10, 32'h0, "R1");

    // R7 clamp
    cur_req = "R7";
    wr(5'h08, 32'h10);
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'hFF, "R7");

    // R2 / R3 / R9 enable load and countdown
    cur_req = "R3";
    wr(5'h08, 32'h300);
    wr(5'h00, 32'h1);
    idle(10);
    rd_chk(5'h14, 32'h0, "R9");
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2F4, "R3");
    idle(5);
    rd_chk(5'h14, 32'h2F4, "R9");

    // R4 good service
    cur_req = "R4";
    wr(5'h00, 32'h1);
    idle(20);
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'hB480);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2FF, "R4");

    // R5 broken sequences
    cur_req = "R5";
    wr(5'h00, 32'h1);
    idle(20);
    wr(5'h10, 32'hB480);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2EA, "R5");
    wr(5'h00, 32'h1);
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'h1234);
    wr(5'h10, 32'hB480);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2FC, "R5");
    wr(5'h00, 32'h1);
    idle(3);
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'hB480);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2FF, "R5");

    // R6 deferred reload value
    cur_req = "R6";
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h120);
    idle(5);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2F9, "R6");
    wr(5'h00, 32'h1);
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'hB480);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h11F, "R6");

    // R8 gating
    cur_req = "R8";
    wr(5'h08, 32'h300);
    halt_i = 1;
    wr(5'h00, 32'h3);
    idle(30);
    wr(5'h00, 32'h2);
    rd_chk(5'h14, 32'h300, "R8");
    halt_i = 0;
    lowpwr_i = 1;
    wr(5'h00, 32'h5);
    idle(30);
    wr(5'h00, 32'h4);
    rd_chk(5'h14, 32'h300, "R8");
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h0);
    rd_chk(5'h14, 32'h2FF, "R8");
    lowpwr_i = 0;

    // R11 service while stopped
    cur_req = "R11";
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'hB480);
    rd_chk(5'h14, 32'h2FF, "R11");

    // R10 expiry
    cur_req = "R10";
    wr(5'h08, 32'h100);
    wr(5'h00, 32'h1);
    idle(200);
    flag_chk(0, "R10");
    idle(100);
    flag_chk(1, "R10");
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h1);
    wr(5'h10, 32'hA602);
    wr(5'h10, 32'hB480);
    idle(2);
    flag_chk(1, "R10");
    rst = 1;
    idle(2);
    rst = 0;
    flag_chk(0, "R10");
    rd_chk(5'h00, 32'h0, "R1");
    idle(2);
    finish_up();
  end
endmodule